// File: doc/BRIEF.md
# Debug Run-Control Register Block

This block holds the run-control and status registers of a debug unit that sits beside a group of harts. A debugger reaches it through a small register bus: one request per cycle, carrying a valid strobe, a write flag, a word address and write data. Every request gets a response on the following cycle with read data and an error flag.

Through a control register, the debugger selects one hart, asks it to halt or resume, and resets either that hart or the whole system. Each hart has its own halt-request and resume-request output, and a reset output. The status register summarises the selected hart from its halted and resume-acknowledge inputs. A constant hart-info register describes the data area that the debug unit presents to the harts. The hart count, the selector width and the data-area geometry are parameters.

Top module: `dbgrc_top`

Register map: control at word address 0x10, status at 0x11, hart-info at 0x12.
Control word layout: bit 0 active, bit 1 system reset, bit 2 hart reset, bit 3 resume request, bit 4 halt request, bits [8+SEL_W-1:8] hart selector.
Status word layout: bits [3:0] version (reads 2), bit 7 authenticated (reads 1), bit 8 any-halted, bit 9 all-halted, bit 10 any-running, bit 11 all-running, bit 12 any-nonexistent, bit 13 all-nonexistent, bit 14 any-resume-ack, bit 15 all-resume-ack.
Hart-info layout: bits [11:0] data base address, bits [15:12] data word count, bit 16 data-access flag, bits [23:20] scratch register count.

## Requirements
- R1: A write to control always stores bit 0 (active). The selector, halt, resume and both reset fields change only when the written bit 0 is 1. When bit 0 is 0 those fields keep their previous values.
- R2: A control write with bit 0 set loads the written halt bit (bit 4) into the halt-request output of the hart that the written selector names. The halt-request outputs of all other harts keep their values.
- R3: A control write with bit 0 and bit 3 set raises the resume-request output of the selected hart and clears its acknowledge flag. A one-cycle pulse on a hart's resume-acknowledge input sets that hart's acknowledge flag and drops its resume-request output.
- R4: While the system-reset field (bit 1) is 1, the system-reset output and every hart-reset output are high. While the hart-reset field (bit 2) is 1, only the selected hart's reset output is high.
- R5: For a selected hart that exists, a status read sets both halted bits (8, 9) when its halted input is 1, and both running bits (10, 11) when that input is 0.
- R6: If the selector is at least the hart count, a status read shows only the nonexistent bits (12, 13) and the constant fields. A halt request written with that selector changes no halt-request output.
- R7: Each any-bit of status equals its matching all-bit. Bits 14 and 15 show the selected hart's acknowledge flag.
- R8: Status always reads version 2 in bits [3:0] and authenticated 1 in bit 7. Writes to status or hart-info change nothing.
- R9: Hart-info reads the data base address, the data word count, a data-access flag of 1 and a scratch count of 1. With default parameters this reads 0x00112380.
- R10: A control read returns the current halt-request output of the selected hart in bit 4, together with the stored fields.
- R11: Every request is answered exactly one cycle later with the response valid flag. A read of any address outside 0x10 to 0x12 returns 0 with the error flag set. Writes and mapped reads return no error.
- R12: Reset clears every register and output: the halt, resume and reset outputs are 0, the selector is 0 and the response valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Register word address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspRdata | output | 32 | Read data (0 for writes) |
| rspErr | output | 1 | Read of an unmapped address |
| hartHalted | input | NUM_HARTS | Per-hart halted state |
| resumeAckIn | input | NUM_HARTS | Per-hart resume-acknowledge pulse |
| haltReqOut | output | NUM_HARTS | Per-hart halt request |
| resumeReqOut | output | NUM_HARTS | Per-hart resume request |
| hartResetOut | output | NUM_HARTS | Per-hart reset |
| sysResetOut | output | 1 | System reset |

## Verification
The bench targets a selector that points past the last hart. A design that indexes its per-hart state without a range check would report halted or running for a hart that does not exist, or would set some real hart's halt request. It also writes control with the active bit clear, which catches a design that loads every field on any write. The bench checks that a new resume request clears an earlier acknowledge and that an acknowledge pulse drops the request. A design that got this wrong would leave stale acknowledge bits in status. It confirms that system reset drives every hart's reset line, that halt requests written to one hart leave the others alone, and that unmapped reads raise the error flag while writes to read-only registers are dropped.

// File: rtl/dbgrc_pkg.sv
package dbgrc_pkg;
  // register word addresses
  localparam int CTRL_ADDR = 'h10;
  localparam int STAT_ADDR = 'h11;
  localparam int INFO_ADDR = 'h12;

  // control word bit positions
  localparam int C_ACTIVE = 0;
  localparam int C_SYSRST = 1;
  localparam int C_HARTRST = 2;
  localparam int C_RESUME = 3;
  localparam int C_HALT = 4;
  localparam int C_SEL_LSB = 8;

  // status constants
  localparam logic [3:0] STAT_VERSION = 4'd2;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic ctrlWr;
    logic rdCtrl;
    logic rdStat;
    logic rdInfo;
  } strobe_t;
endpackage

// File: rtl/dbgrc_ctrl.sv
module dbgrc_ctrl
  import dbgrc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           stb,
  output logic              rspValid,
  output logic              rspErr
);
  logic hitCtrl, hitStat, hitInfo, mapped;

  always_comb begin
    hitCtrl = (reqAddr == ADDR_W'(CTRL_ADDR));
    hitStat = (reqAddr == ADDR_W'(STAT_ADDR));
    hitInfo = (reqAddr == ADDR_W'(INFO_ADDR));
    mapped  = hitCtrl | hitStat | hitInfo;
    stb.ctrlWr = reqValid & reqWrite & hitCtrl;
    stb.rdCtrl = reqValid & ~reqWrite & hitCtrl;
    stb.rdStat = reqValid & ~reqWrite & hitStat;
    stb.rdInfo = reqValid & ~reqWrite & hitInfo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid & ~reqWrite & ~mapped;
    end
  end
endmodule

// File: rtl/dbgrc_dp.sv
module dbgrc_dp
  import dbgrc_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int SEL_W      = 3,
  parameter int DATA_WORDS = 2,
  parameter int DATA_BASE  = 'h380
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [31:0]          wdata,
  input  logic [NUM_HARTS-1:0] hartHalted,
  input  logic [NUM_HARTS-1:0] resumeAckIn,
  output logic [31:0]          rdata,
  output logic [NUM_HARTS-1:0] haltReqOut,
  output logic [NUM_HARTS-1:0] resumeReqOut,
  output logic [NUM_HARTS-1:0] hartResetOut,
  output logic                 sysResetOut
);
  localparam logic [SEL_W:0] HART_LIM = (SEL_W + 1)'(NUM_HARTS);
  localparam logic [31:0] INFO_WORD =
      (32'(1) << 20) | (32'(1) << 16) |
      (32'(DATA_WORDS & 'hF) << 12) | 32'(DATA_BASE & 'hFFF);

  logic             active, sysRst, hartRst, resumeFld;
  logic [SEL_W-1:0] hartSel;
  logic [NUM_HARTS-1:0] ackFlag;
  logic             fieldLoad;
  logic [SEL_W-1:0] newSel;
  logic             selExists, selHalt, selHalted, selAck;
  logic [31:0]      ctrlWord, statWord;

  assign fieldLoad = stb.ctrlWr & wdata[C_ACTIVE];
  assign newSel    = wdata[C_SEL_LSB +: SEL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      sysRst    <= 1'b0;
      hartRst   <= 1'b0;
      resumeFld <= 1'b0;
      hartSel   <= '0;
    end else if (stb.ctrlWr) begin
      active <= wdata[C_ACTIVE];
      if (wdata[C_ACTIVE]) begin
        sysRst    <= wdata[C_SYSRST];
        hartRst   <= wdata[C_HARTRST];
        resumeFld <= wdata[C_RESUME];
        hartSel   <= newSel;
      end
    end
  end

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    logic hitNew;
    assign hitNew = fieldLoad & (newSel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        haltReqOut[i]   <= 1'b0;
        resumeReqOut[i] <= 1'b0;
        ackFlag[i]      <= 1'b0;
      end else begin
        if (hitNew) haltReqOut[i] <= wdata[C_HALT];
        if (hitNew & wdata[C_RESUME]) begin
          resumeReqOut[i] <= 1'b1;
          ackFlag[i]      <= 1'b0;
        end else if (resumeAckIn[i]) begin
          resumeReqOut[i] <= 1'b0;
          ackFlag[i]      <= 1'b1;
        end
      end
    end

    assign hartResetOut[i] = sysRst | (hartRst & (hartSel == SEL_W'(i)));
  end

  assign sysResetOut = sysRst;

  always_comb begin
    selExists = ({1'b0, hartSel} < HART_LIM);
    selHalt   = 1'b0;
    selHalted = 1'b0;
    selAck    = 1'b0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (hartSel == SEL_W'(i)) begin
        selHalt   = haltReqOut[i];
        selHalted = hartHalted[i];
        selAck    = ackFlag[i];
      end
    end

    ctrlWord = '0;
    ctrlWord[C_ACTIVE]  = active;
    ctrlWord[C_SYSRST]  = sysRst;
    ctrlWord[C_HARTRST] = hartRst;
    ctrlWord[C_RESUME]  = resumeFld;
    ctrlWord[C_HALT]    = selHalt;
    ctrlWord[C_SEL_LSB +: SEL_W] = hartSel;

    statWord = '0;
    statWord[3:0] = STAT_VERSION;
    statWord[7]   = 1'b1;
    statWord[9:8]   = {2{selExists & selHalted}};
    statWord[11:10] = {2{selExists & ~selHalted}};
    statWord[13:12] = {2{~selExists}};
    statWord[15:14] = {2{selExists & selAck}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (stb.rdCtrl) rdata <= ctrlWord;
    else if (stb.rdStat) rdata <= statWord;
    else if (stb.rdInfo) rdata <= INFO_WORD;
    else rdata <= '0;
  end
endmodule

// File: rtl/dbgrc_top.sv
module dbgrc_top
  import dbgrc_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int SEL_W      = 3,
  parameter int ADDR_W     = 7,
  parameter int DATA_WORDS = 2,
  parameter int DATA_BASE  = 'h380
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqWdata,
  output logic                 rspValid,
  output logic [31:0]          rspRdata,
  output logic                 rspErr,
  input  logic [NUM_HARTS-1:0] hartHalted,
  input  logic [NUM_HARTS-1:0] resumeAckIn,
  output logic [NUM_HARTS-1:0] haltReqOut,
  output logic [NUM_HARTS-1:0] resumeReqOut,
  output logic [NUM_HARTS-1:0] hartResetOut,
  output logic                 sysResetOut
);
  strobe_t stb;

  dbgrc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .stb(stb), .rspValid(rspValid), .rspErr(rspErr)
  );

  dbgrc_dp #(
    .NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W),
    .DATA_WORDS(DATA_WORDS), .DATA_BASE(DATA_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata),
    .hartHalted(hartHalted), .resumeAckIn(resumeAckIn), .rdata(rspRdata),
    .haltReqOut(haltReqOut), .resumeReqOut(resumeReqOut),
    .hartResetOut(hartResetOut), .sysResetOut(sysResetOut)
  );
endmodule

// File: rtl/dbgrc_chk.sv
module dbgrc_chk
  import dbgrc_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic                 rspValid,
  input logic [31:0]          rspRdata,
  input logic                 rspErr,
  input logic [NUM_HARTS-1:0] resumeAckIn,
  input logic [NUM_HARTS-1:0] haltReqOut,
  input logic [NUM_HARTS-1:0] resumeReqOut,
  input logic [NUM_HARTS-1:0] hartResetOut,
  input logic                 sysResetOut
);
  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r11_err_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  a_r4_sys_resets_all: assert property (@(posedge clk) disable iff (!rstN)
    sysResetOut |-> (&hartResetOut));

  a_r2_halt_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> $stable(haltReqOut));

  a_r3_ack_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> ((resumeReqOut & $past(resumeAckIn)) == '0));

  a_r8_status_constants: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == ADDR_W'(STAT_ADDR))
      |=> (rspRdata[7:0] == 8'h82));
endmodule

bind dbgrc_top dbgrc_chk #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .rspValid(rspValid), .rspRdata(rspRdata),
  .rspErr(rspErr), .resumeAckIn(resumeAckIn), .haltReqOut(haltReqOut),
  .resumeReqOut(resumeReqOut), .hartResetOut(hartResetOut),
  .sysResetOut(sysResetOut)
);

// File: tb/tb_dbgrc_top.sv
`timescale 1ns/1ps
module tb_dbgrc_top;
  localparam int NH = 4;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid, rspErr, sysResetOut;
  logic [31:0] rspRdata;
  logic [NH-1:0] hartHalted = '0, resumeAckIn = '0;
  logic [NH-1:0] haltReqOut, resumeReqOut, hartResetOut;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  dbgrc_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .rspErr(rspErr), .hartHalted(hartHalted),
    .resumeAckIn(resumeAckIn), .haltReqOut(haltReqOut),
    .resumeReqOut(resumeReqOut), .hartResetOut(hartResetOut),
    .sysResetOut(sysResetOut)
  );

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [3:0]  halted;
    logic [31:0] expRd;
    logic        expErr;
    logic [3:0]  expHalt;
  } vec_t;

  // status words: 0xC82 running, 0x382 halted, 0x3082 nonexistent
  localparam vec_t VECS [16] = '{
    '{1'b0, 7'h11, 32'h0,        4'h0, 32'h00000C82, 1'b0, 4'h0}, // R5 running
    '{1'b1, 7'h10, 32'h111,      4'h0, 32'h0,        1'b0, 4'h2}, // R2 sel1 halt
    '{1'b0, 7'h10, 32'h0,        4'h0, 32'h00000111, 1'b0, 4'h2}, // R10
    '{1'b0, 7'h11, 32'h0,        4'h2, 32'h00000382, 1'b0, 4'h2}, // R5 halted
    '{1'b1, 7'h10, 32'h201,      4'h2, 32'h0,        1'b0, 4'h2}, // R2 sel2
    '{1'b0, 7'h10, 32'h0,        4'h2, 32'h00000201, 1'b0, 4'h2}, // R10
    '{1'b0, 7'h11, 32'h0,        4'h2, 32'h00000C82, 1'b0, 4'h2}, // R7
    '{1'b1, 7'h10, 32'h501,      4'h2, 32'h0,        1'b0, 4'h2}, // R6 sel5
    '{1'b0, 7'h11, 32'h0,        4'hF, 32'h00003082, 1'b0, 4'h2}, // R6
    '{1'b0, 7'h10, 32'h0,        4'h2, 32'h00000501, 1'b0, 4'h2}, // R10
    '{1'b1, 7'h10, 32'h110,      4'h2, 32'h0,        1'b0, 4'h2}, // R1 inactive
    '{1'b0, 7'h10, 32'h0,        4'h2, 32'h00000500, 1'b0, 4'h2}, // R1
    '{1'b0, 7'h12, 32'h0,        4'h2, 32'h00112380, 1'b0, 4'h2}, // R9
    '{1'b0, 7'h3F, 32'h0,        4'h2, 32'h0,        1'b1, 4'h2}, // R11
    '{1'b1, 7'h11, 32'hFFFFFFFF, 4'h2, 32'h0,        1'b0, 4'h2}, // R8 ignored
    '{1'b0, 7'h11, 32'h0,        4'h2, 32'h00003082, 1'b0, 4'h2}  // R8
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample the response at the next falling edge
  task automatic doOp(input logic wr, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] rd,
                      output logic err, output logic vld);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    rd = rspRdata; err = rspErr; vld = rspValid;
    reqValid = 1'b0; reqWrite = 1'b0; reqWdata = '0;
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic err, vld;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 haltReq", 32'(haltReqOut), 32'h0);
    check("R12 resumeReq", 32'(resumeReqOut), 32'h0);
    check("R12 resets", {sysResetOut, 27'h0, hartResetOut}, 32'h0);
    check("R12 rspValid", 32'(rspValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      hartHalted = VECS[i].halted;
      doOp(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, err, vld);
      check($sformatf("R11 valid vec%0d", i), 32'(vld), 32'h1);
      check($sformatf("R11 err vec%0d", i), 32'(err), 32'(VECS[i].expErr));
      if (!VECS[i].wr)
        check($sformatf("R5-group read vec%0d", i), rd, VECS[i].expRd);
      check($sformatf("R2 halt vec%0d", i), 32'(haltReqOut), 32'(VECS[i].expHalt));
    end
    @(negedge clk);
    check("R11 idle no rsp", 32'(rspValid), 32'h0);

    // R6: halt request to a nonexistent hart changes no output
    doOp(1'b1, 7'h10, 32'h611, rd, err, vld);
    check("R6 halt to nonexistent", 32'(haltReqOut), 32'h2);

    // R3 resume handshake on hart 0
    hartHalted = 4'h0;
    doOp(1'b1, 7'h10, 32'h009, rd, err, vld);
    check("R3 resume raised", 32'(resumeReqOut), 32'h1);
    check("R2 hart0 halt cleared", 32'(haltReqOut), 32'h2);
    resumeAckIn = 4'h1;
    @(negedge clk);
    resumeAckIn = 4'h0;
    check("R3 ack drops request", 32'(resumeReqOut), 32'h0);
    doOp(1'b0, 7'h11, 32'h0, rd, err, vld);
    check("R7 ack bits", rd, 32'h0000CC82);
    doOp(1'b1, 7'h10, 32'h009, rd, err, vld);
    check("R3 re-request", 32'(resumeReqOut), 32'h1);
    doOp(1'b0, 7'h11, 32'h0, rd, err, vld);
    check("R3 ack cleared", rd, 32'h00000C82);

    // R4 resets
    doOp(1'b1, 7'h10, 32'h305, rd, err, vld);
    check("R4 hart reset sel3", {sysResetOut, 27'h0, hartResetOut}, 32'h8);
    doOp(1'b1, 7'h10, 32'h303, rd, err, vld);
    check("R4 system reset", {sysResetOut, 27'h0, hartResetOut}, 32'h8000000F);
    doOp(1'b1, 7'h10, 32'h001, rd, err, vld);
    check("R4 resets released", {sysResetOut, 27'h0, hartResetOut}, 32'h0);

    // R12 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R12 halt after reset", 32'(haltReqOut), 32'h0);
    check("R12 resume after reset", 32'(resumeReqOut), 32'h0);
    doOp(1'b0, 7'h10, 32'h0, rd, err, vld);
    check("R12 ctrl after reset", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule